// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block sits between a flat memory-mapped read path and a serial flash protocol engine that drives several chip selects. Software programs one segment register per chip select. Each register gives that chip's window as a pair of 8 MB-unit boundaries: an inclusive lower bound and an exclusive upper bound. For every bus request the decoder produces three things one cycle later: a one-hot chip-select vector, the byte offset of the address within the selected window, and an error flag for addresses that no window claims.

Windows are normally laid end to end, so the end of one window is the start of the next. A window whose lower bound is not strictly below its upper bound is treated as switched off, not as a wrapping range. When windows overlap, the lowest chip-select index that matches wins. If the block is built for a single chip select, it has no segment registers, and the whole address space belongs to chip 0.

Top module: `flash_win_decode`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_cs` and `rsp_err` are 0. Chip select i holds the window [i*DEF_UNITS, (i+1)*DEF_UNITS) in 8 MB units, so its readback value is {end, start, 16'h0}.
- R2: A write with `reg_we`=1 and `reg_sel`<NUM_CS stores `reg_wdata[31:24]` as the window end and `reg_wdata[23:16]` as the window start. The new value takes effect on the next cycle. The readback returns both fields in the same positions, with bits [15:0] always 0.
- R3: A write whose `reg_sel` is NUM_CS or above changes no window and no decode result. Reading such an index returns 0.
- R4: A request whose unit index `req_addr[30:23]` satisfies start <= unit < end for an open window sets exactly that chip's bit in `rsp_cs`, with `rsp_err`=0.
- R5: A window whose start is greater than or equal to its end is closed. No address selects it.
- R6: When several open windows contain an address, the lowest chip-select index is selected.
- R7: On a hit, `rsp_offset` equals `req_addr` minus (start << 23), taken modulo 2^31.
- R8: A request that hits no open window gives `rsp_err`=1, with `rsp_cs`=0 and `rsp_offset`=0.
- R9: The response appears on the cycle after `req_valid` is sampled high. A cycle without a request gives `rsp_valid`=0, `rsp_cs`=0 and `rsp_err`=0.
- R10: With NUM_CS=1, every request selects chip 0 with `rsp_offset`=`req_addr` and no error. Register writes are ignored, and every register reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Segment register write strobe |
| reg_sel | input | SEL_W | Chip-select index of the register to write or read |
| reg_wdata | input | 32 | Write data: [31:24] end, [23:16] start |
| reg_rdata | output | 32 | Combinational readback of the selected register |
| req_valid | input | 1 | Bus request present |
| req_addr | input | ADDR_W | Bus byte address (ADDR_W = GRAN_LOG2 + 8) |
| rsp_valid | output | 1 | Registered response valid |
| rsp_cs | output | NUM_CS | One-hot chip select |
| rsp_offset | output | ADDR_W | Byte offset inside the selected window |
| rsp_err | output | 1 | Address hit no open window |

## Verification
On every cycle, the assertions check the following:
- The chip-select output is at most one-hot.
- An error response carries no chip select.
- The response follows the request by exactly one cycle, and idle cycles stay quiet.
- A closed window is never selected.
- A register write lands intact, and a write to an out-of-range index leaves every window untouched.

Only the bench's sweeps can show that the decode is correct. These sweeps compare the chosen chip, the subtracted offset and the miss flag against an arithmetic model over every unit index. They run under default, reprogrammed, closed and overlapping window layouts, and they also exercise the single-chip variant.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;

    localparam int SEG_W = 8;
    localparam int REG_W = 32;

    // hi = exclusive window end, lo = inclusive window start, both in 8 MB units
    typedef struct packed {
        logic [SEG_W-1:0] hi;
        logic [SEG_W-1:0] lo;
    } seg_t;

    function automatic logic [REG_W-1:0] seg_pack(seg_t s);
        return {s.hi, s.lo, 16'h0000};
    endfunction

    function automatic seg_t seg_unpack(logic [REG_W-1:0] w);
        seg_t s;
        s.hi = w[31:24];
        s.lo = w[23:16];
        return s;
    endfunction

endpackage

// File: rtl/flash_seg_regs.sv
module flash_seg_regs
    import flash_win_pkg::*;
#(
    parameter int NUM_CS    = 3,
    parameter int SEL_W     = 3,
    parameter int DEF_UNITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output seg_t [NUM_CS-1:0]     segs_o
);

    typedef struct packed {
        seg_t [NUM_CS-1:0] seg;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic bank_t reset_bank();
        bank_t b;
        for (int i = 0; i < NUM_CS; i++) begin
            b.seg[i].lo = SEG_W'(i * DEF_UNITS);
            b.seg[i].hi = SEG_W'((i + 1) * DEF_UNITS);
        end
        return b;
    endfunction

    always_comb begin
        bank_d    = bank_q;
        reg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (reg_we && reg_sel == SEL_W'(i)) begin
                bank_d.seg[i] = seg_unpack(reg_wdata);
            end
            if (reg_sel == SEL_W'(i)) begin
                reg_rdata = seg_pack(bank_q.seg[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= reset_bank();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign segs_o = bank_q.seg;

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel >= SEL_W'(NUM_CS)) |=> $stable(segs_o));

    for (genvar g = 0; g < NUM_CS; g++) begin : g_wr_chk
        // R2
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_sel == SEL_W'(g)) |=> segs_o[g] == seg_unpack($past(reg_wdata)));
    end

endmodule

// File: rtl/flash_win_match.sv
module flash_win_match
    import flash_win_pkg::*;
#(
    parameter int NUM_CS    = 3,
    parameter int GRAN_LOG2 = 23,
    localparam int ADDR_W   = GRAN_LOG2 + SEG_W
) (
    input  seg_t [NUM_CS-1:0]  segs_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_CS-1:0]  open_o,
    output logic [NUM_CS-1:0]  hit_o
);

    logic [SEG_W-1:0] unit;
    assign unit = addr_i[ADDR_W-1:GRAN_LOG2];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign open_o[g] = segs_i[g].lo < segs_i[g].hi;
        assign hit_o[g]  = open_o[g] && (unit >= segs_i[g].lo) && (unit < segs_i[g].hi);
    end

endmodule

// File: rtl/flash_win_pick.sv
module flash_win_pick
    import flash_win_pkg::*;
#(
    parameter int NUM_CS    = 3,
    parameter int GRAN_LOG2 = 23,
    localparam int ADDR_W   = GRAN_LOG2 + SEG_W
) (
    input  seg_t [NUM_CS-1:0]  segs_i,
    input  logic [NUM_CS-1:0]  hit_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_CS-1:0]  cs_o,
    output logic [ADDR_W-1:0]  off_o,
    output logic               miss_o
);

    logic             found;
    logic [SEG_W-1:0] base;

    always_comb begin
        cs_o  = '0;
        base  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit_i[i] && !found) begin
                found   = 1'b1;
                cs_o[i] = 1'b1;
                base    = segs_i[i].lo;
            end
        end
        miss_o = !found;
        off_o  = addr_i - {base, {GRAN_LOG2{1'b0}}};
    end

endmodule

// File: rtl/flash_win_decode.sv
module flash_win_decode
    import flash_win_pkg::*;
#(
    parameter int NUM_CS    = 3,
    parameter int SEL_W     = 3,
    parameter int GRAN_LOG2 = 23,
    parameter int DEF_UNITS = 4,
    localparam int ADDR_W   = GRAN_LOG2 + SEG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [NUM_CS-1:0]  rsp_cs,
    output logic [ADDR_W-1:0]  rsp_offset,
    output logic               rsp_err
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [NUM_CS-1:0] cs;
        logic [ADDR_W-1:0] off;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_CS-1:0] pick_cs;
    logic [ADDR_W-1:0] pick_off;
    logic              pick_miss;

    if (NUM_CS > 1) begin : g_multi
        seg_t [NUM_CS-1:0] segs;
        logic [NUM_CS-1:0] open_w;
        logic [NUM_CS-1:0] hit_w;

        flash_seg_regs #(
            .NUM_CS(NUM_CS), .SEL_W(SEL_W), .DEF_UNITS(DEF_UNITS)
        ) u_regs (
            .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
            .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .segs_o(segs)
        );

        flash_win_match #(.NUM_CS(NUM_CS), .GRAN_LOG2(GRAN_LOG2)) u_match (
            .segs_i(segs), .addr_i(req_addr), .open_o(open_w), .hit_o(hit_w)
        );

        flash_win_pick #(.NUM_CS(NUM_CS), .GRAN_LOG2(GRAN_LOG2)) u_pick (
            .segs_i(segs), .hit_i(hit_w), .addr_i(req_addr),
            .cs_o(pick_cs), .off_o(pick_off), .miss_o(pick_miss)
        );

        for (genvar g = 0; g < NUM_CS; g++) begin : g_closed_chk
            // R5
            closed_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_cs[g] |-> $past(open_w[g]));
        end
    end else begin : g_single
        logic unused_regs;
        assign unused_regs = ^{reg_we, reg_sel, reg_wdata};
        assign reg_rdata   = '0;
        assign pick_cs     = NUM_CS'(1);
        assign pick_off    = req_addr;
        assign pick_miss   = 1'b0;
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (pick_miss) begin
                rsp_d.err = 1'b1;
            end else begin
                rsp_d.cs  = pick_cs;
                rsp_d.off = pick_off;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_err    = rsp_q.err;
    assign rsp_cs     = rsp_q.cs;
    assign rsp_offset = rsp_q.off;

    // R4
    onehot_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    // R8
    miss_clears_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_cs == '0 && rsp_offset == '0));

    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_cs == '0 && !rsp_err));

endmodule

// File: tb/flash_win_decode_test.sv
module flash_win_decode_test;

    localparam int NCS = 3;
    localparam int AW  = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata, rdata1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_err, v1, e1;
    logic [NCS-1:0] rsp_cs;
    logic [0:0]    cs1;
    logic [AW-1:0] rsp_offset, off1;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int bs[NCS];
    int be[NCS];

    always #10 clk = ~clk;

    flash_win_decode #(.NUM_CS(NCS), .SEL_W(3), .GRAN_LOG2(23), .DEF_UNITS(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
        .rsp_offset(rsp_offset), .rsp_err(rsp_err)
    );

    flash_win_decode #(.NUM_CS(1), .SEL_W(3), .GRAN_LOG2(23), .DEF_UNITS(4)) uut_single (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(v1), .rsp_cs(cs1),
        .rsp_offset(off1), .rsp_err(e1)
    );

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic rd(int sel, string tag);
        logic [31:0] exp;
        @(negedge clk);
        reg_sel = 3'(sel);
        #1;
        exp = (sel < NCS) ? {8'(be[sel]), 8'(bs[sel]), 16'h0} : 32'h0;
        check(reg_rdata == exp, tag, "readback", reg_rdata, exp);
        check(rdata1 == 32'h0, "R10", "single readback", rdata1, 0);
    endtask

    task automatic wr(int sel, logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b0;
        reg_we    = 1'b1;
        reg_sel   = 3'(sel);
        reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel < NCS) begin
            bs[sel] = int'(data[23:16]);
            be[sel] = int'(data[31:24]);
        end
        check(!rsp_valid && rsp_cs == '0 && !rsp_err, "R9", "idle response",
              {rsp_valid, rsp_cs, rsp_err}, 0);
    endtask

    task automatic do_req(logic [AW-1:0] addr, string tag);
        int u;
        int hit;
        logic [AW-1:0] eoff;
        logic [NCS-1:0] ecs;
        string t;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        u   = int'(addr[30:23]);
        hit = -1;
        for (int i = 0; i < NCS; i++) begin
            if (hit < 0 && bs[i] < be[i] && u >= bs[i] && u < be[i]) hit = i;
        end
        ecs  = '0;
        eoff = '0;
        if (hit >= 0) begin
            ecs[hit] = 1'b1;
            eoff = addr - {8'(bs[hit]), 23'h0};
        end
        t = (hit < 0) ? "R8" : tag;
        check(rsp_valid, "R9", "rsp_valid", rsp_valid, 1);
        check(rsp_cs == ecs, t, "rsp_cs", rsp_cs, ecs);
        check(rsp_err == (hit < 0), t, "rsp_err", rsp_err, hit < 0);
        check(rsp_offset == eoff, (hit < 0) ? "R8" : "R7", "rsp_offset", rsp_offset, eoff);
        check(v1 && cs1 == 1'b1 && !e1 && off1 == addr, "R10", "single decode",
              {v1, cs1, e1}, 3'b110);
    endtask

    task automatic sweep(string tag, bit full);
        for (int u = 0; u < 256; u++) begin
            do_req({8'(u), 23'h000000}, tag);
            if (full) begin
                do_req({8'(u), 23'h7FFFFF}, tag);
                do_req({8'(u), 23'h123456}, tag);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCS; i++) begin
            bs[i] = i * 4;
            be[i] = (i + 1) * 4;
        end
        repeat (3) @(negedge clk);
        check(!rsp_valid && rsp_cs == '0 && !rsp_err, "R1", "reset outputs",
              {rsp_valid, rsp_cs, rsp_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && rsp_cs == '0 && !rsp_err, "R1", "post-reset outputs",
              {rsp_valid, rsp_cs, rsp_err}, 0);
        for (int i = 0; i < NCS; i++) rd(i, "R1");

        sweep("R4", 1'b1);

        wr(0, 32'h0A02_BEEF);
        wr(1, 32'h1E0A_1234);
        wr(2, 32'hC81E_FFFF);
        for (int i = 0; i < NCS; i++) rd(i, "R2");
        sweep("R4", 1'b1);

        wr(3, 32'h0500_0000);
        wr(4, 32'hFF00_0000);
        wr(7, 32'h2010_0000);
        for (int i = 0; i < 5; i++) rd(i, "R3");
        rd(7, "R3");
        sweep("R3", 1'b0);

        wr(0, 32'h1E00_0000);
        wr(1, 32'h2828_0000);
        wr(2, 32'h325A_0000);
        for (int i = 0; i < NCS; i++) rd(i, "R2");
        sweep("R5", 1'b1);

        wr(0, 32'h3C14_0000);
        wr(1, 32'h640A_0000);
        wr(2, 32'hFF00_0000);
        sweep("R6", 1'b1);

        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(!rsp_valid && rsp_cs == '0 && !rsp_err, "R9", "final idle",
              {rsp_valid, rsp_cs, rsp_err}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule